// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a two-wire serial slave that gives a bus master byte access to a 256-location register space. A fast system clock samples SCL and SDA. The block finds START and STOP conditions and answers only to its own 7-bit device address. After a write address it takes one byte as the register pointer. It then stores each later byte at the pointer and moves the pointer on by one. After a read address it shifts out bytes from the pointer and also advances after each byte.

One location acts as an output-enable register. Its six low bits appear directly on six enable outputs, and its two high bits can never be set. The pointer keeps its value across a STOP. A master can therefore re-read or continue a burst without sending a new pointer byte. The block drives SDA open-drain: it can only request a low level, and the bus resolves as a wired AND.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new transaction from any state, including partway through a byte. A STOP (SDA rising while SCL is high) returns the slave to idle and releases SDA.
- R2: The first byte after a START carries the 7-bit device address in its upper seven bits and the read/write flag (1 = read) in its lowest bit.
  - When the address equals the `DEV_ADDR` parameter, the slave pulls SDA low for the ninth clock.
  - Otherwise it never drives SDA and changes no register until the next START or STOP.
- R3: In a write transaction, the slave loads the first byte after the address into the register pointer. Each later byte is stored at the pointer. Every byte is acknowledged on its ninth clock.
- R4: The pointer advances by one after every data byte written or read, and it wraps from FFh to 00h.
- R5: After an address byte with the flag set to 1 and its acknowledge, the slave shifts out the byte at the pointer, most significant bit first. It drives SDA low only for 0 bits.
- R6: When the master drives SDA low on the ninth clock of a read byte, the slave sends the next byte. When the master leaves SDA high, the slave stops driving until the next START or STOP.
- R7: Bit n of register 09h (n = 0..5) drives `clk_en[n]`. Bits 7:6 of that register always read as zero, whatever is written.
- R8: The pointer keeps its value across a STOP. A read without a pointer byte continues from where the last transfer left it.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: After reset, every register is zero, `sda_oe` is 0 and `clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired AND) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| clk_en | output | 6 | Enable outputs from register 09h bits 5:0 |

## Verification
The assertions rely on these assumptions:
- The master obeys the bus rules: it changes SDA only while SCL is low, except when it makes a START or STOP.
- Each SCL phase lasts at least a few system clocks, so the synchronised SCL is already low whenever the slave changes its drive.

The stimulus respects these assumptions:
- The bench master holds each SCL phase for ten system clocks.
- It changes data three clocks after each SCL fall.
- It releases SDA for every bit that the slave may drive.

Under those conditions the drive and enable outputs are compared with a behavioural model on every clock while SCL is high.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         AW       = 8,
  parameter int         NOE      = 6,
  parameter logic [7:0] OE_REG   = 8'h09
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  output logic [NOE-1:0] clk_en
);
  localparam int         NREG    = 1 << AW;
  localparam logic [7:0] OE_MASK = 8'((1 << NOE) - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_REG, S_WR, S_ACK, S_TX, S_MACK, S_OFF
  } st_t;

  st_t           st, ack_to;
  logic [2:0]    scl_q, sda_q;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx;
  logic [AW-1:0] ptr;
  logic          mack;
  logic [7:0]    mem [NREG];

  wire scl_s    = scl_q[1];
  wire scl_d    = scl_q[2];
  wire sda_s    = sda_q[1];
  wire sda_d    = sda_q[2];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire byte_end = scl_fall && (cnt == 4'd8);

  wire [7:0] rd_byte = mem[ptr];
  wire [7:0] wr_byte = (ptr == AW'(OE_REG)) ? (sh & OE_MASK) : sh;

  assign clk_en = mem[AW'(OE_REG)][NOE-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= '1;
      sda_q  <= '1;
      st     <= S_IDLE;
      ack_to <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (start_c) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_REG, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (st == S_DEV) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  ack_to <= sh[0] ? S_TX : S_REG;
                  st     <= S_ACK;
                end else begin
                  st <= S_OFF;
                end
              end else begin
                if (st == S_REG) begin
                  ptr <= sh[AW-1:0];
                end else begin
                  mem[ptr] <= wr_byte;
                  ptr      <= ptr + 1'b1;
                end
                sda_oe <= 1'b1;
                ack_to <= S_WR;
                st     <= S_ACK;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (ack_to == S_TX) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ack_to;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                st     <= S_MACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                st     <= S_TX;
              end else begin
                st <= S_OFF;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk #(
  parameter int AW  = 8,
  parameter int NOE = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_sy,
  input logic          stop_c,
  input logic [2:0]    st_q,
  input logic [AW-1:0] ptr,
  input logic          sda_oe,
  input logic [7:0]    oe_reg
);
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_REG  = 3'd2;
  localparam logic [2:0] ST_MACK = 3'd6;
  localparam logic [2:0] ST_OFF  = 3'd7;

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st_q == ST_IDLE && !sda_oe));

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |-> !sda_oe);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && $past(st_q) != ST_REG) |-> ptr == AW'($past(ptr) + 1'b1));

  // R6
  mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MACK) |-> !sda_oe);

  // R7
  oe_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_reg >> NOE) == 8'd0);

  // R9
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sy);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.AW(AW), .NOE(NOE)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sy(scl_q[1]), .stop_c(stop_c), .st_q(st),
  .ptr(ptr), .sda_oe(sda_oe), .oe_reg(mem[AW'(OE_REG)])
);

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
  localparam logic [6:0] DEV = 7'h69;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [5:0] clk_en;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_oe = 1'b0;
  logic [5:0] exp_en = '0;
  bit mon_on = 0;
  string tag = "R9";
  logic [7:0] model [256];
  logic [7:0] mptr = '0;
  logic [7:0] wq [$];

  always #2 clk = ~clk;

  i2c_regfile_slave #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .clk_en(clk_en)
  );

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on && scl_m) begin
      chk(sda_oe == exp_oe, tag, "sda_oe", sda_oe, exp_oe);
      chk(clk_en == exp_en, "R7", "clk_en", clk_en, exp_en);
    end
  end

  task automatic half(); repeat (10) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; exp_oe = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; exp_oe = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic clk_bit(input bit b, input bit e, output bit got);
    repeat (3) @(negedge clk);
    sda_m = b; exp_oe = e;
    repeat (7) @(negedge clk);
    scl_m = 1'b1;
    repeat (5) @(negedge clk);
    got = sda_bus;
    repeat (5) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic send8(input logic [7:0] v);
    bit g;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], 1'b0, g);
  endtask

  task automatic ack_phase(input bit e, input string r);
    bit g;
    clk_bit(1'b1, e, g);
    chk(g == !e, r, "ack bit", g, !e);
  endtask

  task automatic read8(input string r);
    bit g;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~model[mptr][i], g);
      v[i] = g;
    end
    chk(v == model[mptr], r, "read byte", v, model[mptr]);
    mptr++;
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] ra);
    bit hit;
    hit = (a == DEV);
    do_start();
    send8({a, 1'b0});
    ack_phase(hit, "R2");
    send8(ra);
    ack_phase(hit, hit ? "R3" : "R2");
    if (hit) mptr = ra;
    foreach (wq[i]) begin
      send8(wq[i]);
      if (hit) begin
        model[mptr] = (mptr == 8'h09) ? (wq[i] & 8'h3F) : wq[i];
        exp_en = model[9][5:0];
        mptr++;
      end
      ack_phase(hit, hit ? "R3" : "R2");
    end
    do_stop();
  endtask

  task automatic read_txn(input bit set_ptr, input logic [7:0] ra, input int n, input string r);
    bit g;
    if (set_ptr) begin
      do_start();
      send8({DEV, 1'b0});
      ack_phase(1'b1, "R2");
      send8(ra);
      ack_phase(1'b1, "R5");
      mptr = ra;
    end
    do_start();
    send8({DEV, 1'b1});
    ack_phase(1'b1, "R5");
    tag = r;
    for (int i = 0; i < n; i++) begin
      read8(r);
      clk_bit((i == n - 1) ? 1'b1 : 1'b0, 1'b0, g);
    end
    tag = "R6";
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, 1'b0, g);
      chk(g == 1'b1, "R6", "bus after nack", g, 1);
    end
    tag = "R9";
    do_stop();
  endtask

  initial begin
    bit g;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0, "R10", "sda_oe in reset", sda_oe, 0);
    chk(clk_en == 6'd0, "R10", "clk_en in reset", clk_en, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;
    read_txn(1'b1, 8'h40, 2, "R10");

    wq.delete(); wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    write_txn(DEV, 8'h20);
    read_txn(1'b1, 8'h20, 3, "R3");

    wq.delete(); wq.push_back(8'hFF);
    write_txn(DEV, 8'h09);
    read_txn(1'b1, 8'h09, 1, "R7");

    wq.delete(); wq.push_back(8'hA1); wq.push_back(8'hB2); wq.push_back(8'hC3);
    write_txn(DEV, 8'hFE);
    read_txn(1'b1, 8'hFE, 3, "R4");
    read_txn(1'b0, 8'h00, 2, "R8");

    wq.delete(); wq.push_back(8'h00);
    write_txn(7'h2A, 8'h09);
    read_txn(1'b1, 8'h09, 1, "R2");

    // R1: stop in the middle of a pointer byte
    do_start();
    send8({DEV, 1'b0});
    ack_phase(1'b1, "R1");
    for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, g);
    do_stop();
    read_txn(1'b0, 8'h00, 2, "R1");

    // R1: repeated start in the middle of a data byte
    do_start();
    send8({DEV, 1'b0});
    ack_phase(1'b1, "R1");
    send8(8'h30);
    ack_phase(1'b1, "R1");
    for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, g);
    wq.delete(); wq.push_back(8'hD5); wq.push_back(8'h5A);
    write_txn(DEV, 8'h09);
    read_txn(1'b1, 8'h08, 3, "R7");
    read_txn(1'b1, 8'h30, 1, "R1");

    mon_on = 0;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule